// File: doc/BRIEF.md
# Sync-Aligned Flushing Sinc3 Measurement Sequencer

This block sequences a third-order sinc decimator that runs in on-off mode, next to a sigma-delta modulator that is clocked without a break. It divides the system clock into a free-running modulator clock. Each pulse on the sync input, normally the start of a PWM period, starts a timer. When the timer expires, the sequencer clears every filter state. It then issues integrator sample strobes and decimation strobes for exactly three decimation periods and captures the filter output. As a result, the impulse response of the filter is centred on a chosen point after the sync pulse.

The measurement point is set as an offset in system clock cycles. The sequencer subtracts one and a half decimation periods from the offset to find where the timer expires. Because every measurement begins from a flushed filter, the modulator divider, the decimation rate and the sync period need no integer relationship, and the sync period may change from one pulse to the next. A captured word is held in a result register. An interrupt stays raised until the host acknowledges it, and a sticky flag records any capture that lands on an interrupt that has not been acknowledged.

Top module: `sinc3_flush_ctrl`

## Requirements
- R1: With divider value D (values below 2 act as 2), `mclk_o` has a period of D system cycles. In each period it is low for the first floor(D/2) cycles and high for the rest. It runs continuously from reset, whatever the sync and measurement activity.
- R2: A rising edge on `sync_i` in cycle n makes `filt_clr` high for the single cycle n+1+T. Here T = offset − floor(3·R·D/2) when the offset is larger than that product term, and T = 0 otherwise (R is the decimation rate, with 0 acting as 1).
- R3: `integ_en` is a one-cycle strobe. It occurs only in the last system cycle of a modulator period, and only between a flush and the matching capture. It is never high at the same time as `filt_clr`.
- R4: `dec_en` is high together with every R-th `integ_en` counted from the flush. A measurement window contains exactly 3·R integrator strobes and exactly 3 decimation strobes.
- R5: `capture` is high for one cycle, in the cycle after the third decimation strobe. After it, both strobes stay low until the next flush.
- R6: `result` takes the value that `filt_data` had during the capture cycle and shows it from the following cycle.
- R7: `irq` rises in the cycle after a capture and stays high until `irq_ack` is sampled high. It is low in the cycle after the acknowledge unless a capture happens in that same cycle.
- R8: `overrun` is set when a capture happens while `irq` is high and `irq_ack` is low. Once set, only reset clears it.
- R9: A sync edge that arrives while the sequencer is waiting or filtering stops the current measurement in the same cycle. That measurement produces no capture, and the timer restarts from the new edge.
- R10: Sync pulses at irregular spacing, each followed by its own timing, each yield exactly one capture at the cycle that R2 to R5 give for that pulse.
- R11: During and right after reset, `filt_clr`, `integ_en`, `dec_en`, `capture`, `irq` and `overrun` are low, `result` is zero and `mclk_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Sync pulse; its rising edge starts a measurement |
| mclk_div | input | DIV_W | Modulator clock divider D |
| dec_rate | input | DEC_W | Decimation rate R in modulator periods |
| meas_offset | input | OFS_W | Measurement point after sync, in system cycles |
| filt_data | input | DATA_W | Output word of the sinc3 datapath |
| irq_ack | input | 1 | Host acknowledge of the interrupt |
| mclk_o | output | 1 | Free-running modulator clock |
| filt_clr | output | 1 | One-cycle clear of all filter states |
| integ_en | output | 1 | Integrator sample strobe |
| dec_en | output | 1 | Decimation (differentiator) strobe |
| capture | output | 1 | Strobe that loads the result |
| irq | output | 1 | Measurement-ready interrupt |
| overrun | output | 1 | Sticky flag: a capture hit an interrupt that was not acknowledged |
| result | output | DATA_W | Latched measurement |

## Verification
The hardest case to reach is a sync edge that arrives halfway through the three-period window, after the flush and after some decimation strobes have already fired. Only at that point can a stale decimation count or an ungated strobe leak into the next measurement. The stimulus triggers a measurement and waits long enough to land inside the filtering window. It then pulses sync again and expects exactly one capture, timed from the second edge and with full strobe counts. A separate run aborts while the timer is still counting, and another sets a short offset so that the timer terminal count clamps to zero.

// File: rtl/sinc3_flush_ctrl.sv
module sinc3_flush_ctrl #(
  parameter int DIV_W  = 8,
  parameter int DEC_W  = 12,
  parameter int OFS_W  = 24,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [DIV_W-1:0]  mclk_div,
  input  logic [DEC_W-1:0]  dec_rate,
  input  logic [OFS_W-1:0]  meas_offset,
  input  logic [DATA_W-1:0] filt_data,
  input  logic              irq_ack,
  output logic              mclk_o,
  output logic              filt_clr,
  output logic              integ_en,
  output logic              dec_en,
  output logic              capture,
  output logic              irq,
  output logic              overrun,
  output logic [DATA_W-1:0] result
);

  localparam int PROD_W = DIV_W + DEC_W + 2;
  localparam int CW     = (OFS_W > PROD_W) ? OFS_W : PROD_W;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN, S_CAP} st_t;

  st_t              state;
  logic [DIV_W-1:0] mdiv_cnt, cnt_nxt, eff_d;
  logic [DEC_W-1:0] samp_cnt, eff_r;
  logic [1:0]       dec_cnt;
  logic [CW-1:0]    tmr, lead, ofs_x, tc;
  logic             sync_q, sync_edge, mod_end, timer_hit, last_samp;

  // divider and decimation values below the legal minimum are clamped
  assign eff_d   = (mclk_div < DIV_W'(2)) ? DIV_W'(2) : mclk_div;
  assign eff_r   = (dec_rate == '0) ? DEC_W'(1) : dec_rate;
  assign mod_end = (mdiv_cnt >= eff_d - DIV_W'(1));
  assign cnt_nxt = mod_end ? '0 : mdiv_cnt + DIV_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdiv_cnt <= '0;
      mclk_o   <= 1'b0;
    end else begin
      mdiv_cnt <= cnt_nxt;
      mclk_o   <= (cnt_nxt >= (eff_d >> 1));
    end
  end

  // timer terminal count: offset minus 1.5 decimation periods, clamped at zero
  assign lead  = (CW'(eff_d) * CW'(eff_r) * CW'(3)) >> 1;
  assign ofs_x = CW'(meas_offset);
  assign tc    = (ofs_x > lead) ? ofs_x - lead : '0;

  assign sync_edge = sync_i & ~sync_q;
  assign timer_hit = (state == S_WAIT) && (tmr == tc);
  assign last_samp = (samp_cnt >= eff_r - DEC_W'(1));

  assign filt_clr = timer_hit & ~sync_edge;
  assign integ_en = (state == S_RUN) & mod_end & ~sync_edge;
  assign dec_en   = integ_en & last_samp;
  assign capture  = (state == S_CAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      state    <= S_IDLE;
      tmr      <= '0;
      samp_cnt <= '0;
      dec_cnt  <= '0;
    end else begin
      sync_q <= sync_i;
      if (sync_edge && state != S_CAP) begin
        state <= S_WAIT;
        tmr   <= '0;
      end else begin
        case (state)
          S_WAIT: begin
            if (timer_hit) begin
              state    <= S_RUN;
              samp_cnt <= '0;
              dec_cnt  <= '0;
            end else begin
              tmr <= tmr + CW'(1);
            end
          end
          S_RUN: begin
            if (integ_en) begin
              if (last_samp) begin
                samp_cnt <= '0;
                dec_cnt  <= dec_cnt + 2'd1;
                if (dec_cnt == 2'd2) state <= S_CAP;
              end else begin
                samp_cnt <= samp_cnt + DEC_W'(1);
              end
            end
          end
          S_CAP: begin
            state <= sync_edge ? S_WAIT : S_IDLE;
            tmr   <= '0;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      overrun <= 1'b0;
      result  <= '0;
    end else begin
      if (capture) begin
        irq    <= 1'b1;
        result <= filt_data;
        if (irq && !irq_ack) overrun <= 1'b1;
      end else if (irq_ack) begin
        irq <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sinc3_flush_ctrl_chk.sv
module sinc3_flush_ctrl_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_ack,
  input logic [DATA_W-1:0] filt_data,
  input logic              filt_clr,
  input logic              integ_en,
  input logic              dec_en,
  input logic              capture,
  input logic              irq,
  input logic              overrun,
  input logic [DATA_W-1:0] result
);

  a_r3_clr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    filt_clr |-> !integ_en);

  a_r4_dec_with_integ: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |-> integ_en);

  a_r5_cap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!integ_en && !dec_en && !filt_clr));

  a_r5_cap_after_dec: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> $past(dec_en));

  a_r6_result_load: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (result == $past(filt_data)));

  a_r7_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> irq);

  a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  a_r8_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($past(capture) && $past(irq) && !$past(irq_ack)));

endmodule

bind sinc3_flush_ctrl sinc3_flush_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .filt_data(filt_data),
  .filt_clr(filt_clr), .integ_en(integ_en), .dec_en(dec_en),
  .capture(capture), .irq(irq), .overrun(overrun), .result(result)
);

// File: tb/tb_sinc3_flush_ctrl.sv
module tb_sinc3_flush_ctrl;
  localparam int CLK_P  = 10;
  localparam int DIV_W  = 8;
  localparam int DEC_W  = 12;
  localparam int OFS_W  = 24;
  localparam int DATA_W = 24;
  localparam int D      = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 1'b0;
  logic [DIV_W-1:0]  mclk_div = DIV_W'(D);
  logic [DEC_W-1:0]  dec_rate = DEC_W'(4);
  logic [OFS_W-1:0]  meas_offset = '0;
  logic [DATA_W-1:0] filt_data = '0;
  logic irq_ack = 1'b0;
  logic mclk_o, filt_clr, integ_en, dec_en, capture, irq, overrun;
  logic [DATA_W-1:0] result;

  sinc3_flush_ctrl #(.DIV_W(DIV_W), .DEC_W(DEC_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .mclk_div(mclk_div),
    .dec_rate(dec_rate), .meas_offset(meas_offset), .filt_data(filt_data),
    .irq_ack(irq_ack), .mclk_o(mclk_o), .filt_clr(filt_clr),
    .integ_en(integ_en), .dec_en(dec_en), .capture(capture), .irq(irq),
    .overrun(overrun), .result(result)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct { int clr_c; int cap_c; int r; } item_t;
  item_t exp_q[$];

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;
  always @(negedge clk) filt_data <= DATA_W'(cyc * 37 + 11);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic sample();
    @(negedge clk);
    #(CLK_P/4);
  endtask

  // expected timing from R2..R5
  function automatic int exp_cap(input int n, input int ofs, input int r, output int clr);
    int lead, tc, c, k;
    lead = (3 * r * D) / 2;
    tc = (ofs > lead) ? ofs - lead : 0;
    clr = n + 1 + tc;
    c = n + 2 + tc;
    k = 0;
    forever begin
      if (c % D == D - 1) begin
        k++;
        if (k == 3 * r) break;
      end
      c++;
    end
    return c + 1;
  endfunction

  task automatic pulse_sync(input int ofs, input int r, output int n);
    @(negedge clk);
    meas_offset = OFS_W'(ofs);
    dec_rate = DEC_W'(r);
    sync_i = 1'b1;
    n = cyc;
    @(negedge clk);
    sync_i = 1'b0;
  endtask

  task automatic measure(input int ofs, input int r);
    int n, clr, cap;
    item_t it;
    pulse_sync(ofs, r, n);
    cap = exp_cap(n, ofs, r, clr);
    it.clr_c = clr; it.cap_c = cap; it.r = r;
    exp_q.push_back(it);
    while (cyc < cap + 3) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  // monitor: scoreboard for flush, strobes and capture
  int last_clr = -1;
  int integ_cnt = 0;
  int dec_cnt = 0;
  bit in_win = 0;
  bit chk_res = 0;
  logic [DATA_W-1:0] pend_data;

  initial begin
    item_t it;
    forever begin
      sample();
      if (rst_n && !done) begin
        chk(mclk_o == ((cyc % D) >= (D / 2)), "R1 mclk_o", mclk_o, (cyc % D) >= (D / 2));
        if (chk_res) begin
          chk(result == pend_data, "R6 result", result, pend_data);
          chk(irq == 1'b1, "R7 irq after capture", irq, 1);
          chk_res = 0;
        end
        if (sync_i) begin
          chk(!integ_en && !dec_en, "R9 strobes on sync edge", integ_en, 0);
          in_win = 0;
        end
        if (filt_clr) begin
          chk(!integ_en, "R3 clr vs integ", integ_en, 0);
          last_clr = cyc; integ_cnt = 0; dec_cnt = 0; in_win = 1;
        end
        if (integ_en) begin
          if (!in_win) chk(0, "R5 integ_en outside window", 1, 0);
          if (cyc % D != D - 1) chk(0, "R3 integ_en phase", cyc % D, D - 1);
          integ_cnt++;
        end
        if (dec_en) begin
          if (!integ_en) chk(0, "R4 dec_en without integ_en", 0, 1);
          dec_cnt++;
        end
        if (capture) begin
          if (exp_q.size() == 0) begin
            chk(0, "R9 unexpected capture", cyc, -1);
          end else begin
            it = exp_q.pop_front();
            chk(cyc == it.cap_c, "R5 capture cycle", cyc, it.cap_c);
            chk(last_clr == it.clr_c, "R2 flush cycle", last_clr, it.clr_c);
            chk(integ_cnt == 3 * it.r, "R4 integ count", integ_cnt, 3 * it.r);
            chk(dec_cnt == 3, "R4 dec count", dec_cnt, 3);
          end
          pend_data = filt_data;
          chk_res = 1;
          in_win = 0;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    // R11 reset state
    chk({filt_clr, integ_en, dec_en, capture, irq, overrun, mclk_o} == 7'b0, "R11 outputs in reset",
        {filt_clr, integ_en, dec_en, capture, irq, overrun, mclk_o}, 0);
    chk(result == '0, "R11 result in reset", result, 0);
    @(negedge clk);
    rst_n = 1'b1;
    sample();
    chk({filt_clr, integ_en, dec_en, capture, irq, overrun} == 6'b0, "R11 after reset",
        {filt_clr, integ_en, dec_en, capture, irq, overrun}, 0);
    repeat (20) sample();

    // R2/R10 nominal measurement, then R7 acknowledge
    measure(200, 8);
    chk(irq == 1'b1, "R7 irq held", irq, 1);
    ack();
    sample();
    chk(irq == 1'b0, "R7 irq cleared by ack", irq, 0);
    chk(overrun == 1'b0, "R8 no overrun when acked", overrun, 0);

    // R2 terminal count clamped to zero
    measure(10, 4);
    ack();
    // R4 decimation rate one, odd lead
    measure(50, 1);
    ack();

    // R8 overrun: two captures without acknowledge
    measure(60, 3);
    repeat (7) @(negedge clk);
    measure(90, 2);
    sample();
    chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
    ack();
    repeat (5) sample();
    chk(overrun == 1'b1, "R8 overrun sticky", overrun, 1);
    chk(irq == 1'b0, "R7 irq low after ack", irq, 0);

    // R9 abort while filtering (window starts ~57 cycles after sync)
    pulse_sync(100, 6, n);
    repeat (75) @(negedge clk);
    measure(120, 5);
    ack();

    // R9 abort while the timer is still counting
    pulse_sync(400, 2, n);
    repeat (30) @(negedge clk);
    measure(70, 3);
    ack();

    // R10 irregular sync spacing
    for (int i = 0; i < 5; i++) begin
      measure(40 + i * 53, 2 + (i % 3));
      repeat (3 + i * 11) @(negedge clk);
      ack();
    end

    repeat (10) sample();
    chk(exp_q.size() == 0, "R10 all captures seen", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule